// File: doc/BRIEF.md
# DRAM Refresh Timing Scheduler

This block keeps the refresh bookkeeping for one DRAM rank. A 16-bit interval timer runs from the configured average refresh interval. Each time it expires, one more refresh is owed. Each refresh the controller issues pays one back. While any refresh is owed, the block raises a refresh request.

If refreshes are postponed for too long, a prescaled overdue timer crosses a configured ceiling and a panic request is raised. That ceiling is counted in units of 1024 clock cycles. The ceiling is meant to be programmed somewhat early, so that a panic refresh still lands inside the legal limit.

The block also holds off activates and refreshes while a timing window is open. A window opens after a refresh, after an exit from self-refresh, after a long ZQ calibration and after a mode-register write. The exit window is the refresh cycle time plus a short offset. While the rank is in self-refresh the interval timer is held at zero, and it starts counting from zero again on exit.

The controller drives the configuration inputs from its own registers. The usual register values are provided as package constants: interval field 0x62C, refresh cycle 0x80, ceiling 0x9, ZQ time 0x100, mode-register delay 0xC and exit offset 0xB.

Top module: `refresh_sched`

## Requirements
- R1: The interval limit is `{cfg_refi, 1'b0}` (the interval field shifted left by one bit). Counting from reset, or from the cycle after an expiry, the owed count rises exactly limit cycles later.
- R2: An expiry raises `owed` by one and an issued refresh lowers it by one. If both fall in the same cycle, `owed` is unchanged. A refresh issued while `owed` is zero has no effect. `owed` saturates at its all-ones value.
- R3: `ref_req` is high exactly when `owed` is nonzero.
- R4: A refresh strobe holds `cmd_block` high for `cfg_rfc` cycles, counted from the cycle after the strobe. A value of zero opens no window.
- R5: A self-refresh exit strobe holds `cmd_block` high for `cfg_rfc + cfg_xs_off` cycles.
- R6: A ZQ long calibration strobe holds `cmd_block` high for `cfg_zq` cycles.
- R7: A mode-register set strobe holds `cmd_block` high for `cfg_mrd` cycles.
- R8: When windows overlap, or start in the same cycle, `cmd_block` stays high until the longest remaining window has ended.
- R9: The overdue timer advances one unit per 1024 cycles while `owed` is nonzero, counting from the cycle in which `owed` became nonzero. `panic_req` rises once the unit count reaches `cfg_ceiling`. It is only ever high while `ref_req` is high.
- R10: Once `owed` returns to zero, `panic_req` drops and the overdue count is cleared. A later request starts a fresh overdue period.
- R11: From a self-refresh entry strobe until the matching exit strobe, no interval expiry occurs. After the exit strobe, the next expiry comes exactly limit cycles later.
- R12: In reset, `owed` is zero and `ref_req`, `panic_req` and `cmd_block` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_refi | input | 15 | Upper 15 bits of the refresh interval limit |
| cfg_rfc | input | 10 | Refresh cycle time in cycles |
| cfg_ceiling | input | 7 | Postponement ceiling in 1024-cycle units |
| cfg_xs_off | input | 4 | Extra cycles added to the refresh cycle time on self-refresh exit |
| cfg_zq | input | 10 | Long ZQ calibration time in cycles |
| cfg_mrd | input | 5 | Mode-register update delay in cycles |
| ref_issued | input | 1 | A refresh was issued this cycle |
| sr_enter | input | 1 | Self-refresh entry this cycle |
| sr_exit | input | 1 | Self-refresh exit this cycle |
| zq_issued | input | 1 | ZQ long calibration issued this cycle |
| mrs_issued | input | 1 | Mode-register set issued this cycle |
| ref_req | output | 1 | A refresh is owed |
| panic_req | output | 1 | The overdue ceiling has been reached |
| owed | output | OWED_W | Count of owed refreshes |
| cmd_block | output | 1 | Activates and refreshes must be held off |

## Verification
Two pairs of functions can act in the same cycle.

- **Refresh strobe and interval expiry.** The bench drives a refresh strobe on the exact edge where the interval counter expires, and requires `owed` to stay unchanged across that edge.
- **Two blocking windows.** The bench starts one window while another is still running, and also starts two windows together. Because it knows where each window ends, it predicts how many cycles `cmd_block` stays high in each case and checks that count.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;
  localparam int REFI_W = 15;
  localparam int RFC_W  = 10;
  localparam int CEIL_W = 7;
  localparam int XOFF_W = 4;
  localparam int ZQ_W   = 10;
  localparam int MRD_W  = 5;
  localparam int LIM_W  = REFI_W + 1;
  localparam int BLK_W  = RFC_W + 1;

  localparam logic [REFI_W-1:0] DEF_REFI = 15'h62C;
  localparam logic [RFC_W-1:0]  DEF_RFC  = 10'h080;
  localparam logic [CEIL_W-1:0] DEF_CEIL = 7'h09;
  localparam logic [ZQ_W-1:0]   DEF_ZQ   = 10'h100;
  localparam logic [MRD_W-1:0]  DEF_MRD  = 5'h0C;
  localparam logic [XOFF_W-1:0] DEF_XOFF = 4'hB;

  // interval limit: field in the upper bits, LSB forced low
  function automatic logic [LIM_W-1:0] interval_limit(input logic [REFI_W-1:0] f);
    return {f, 1'b0};
  endfunction

  // window after leaving self-refresh
  function automatic logic [BLK_W-1:0] exit_delay(input logic [RFC_W-1:0] rfc,
                                                  input logic [XOFF_W-1:0] off);
    return BLK_W'(rfc) + BLK_W'(off);
  endfunction

  function automatic logic [BLK_W-1:0] longer(input logic [BLK_W-1:0] a,
                                              input logic [BLK_W-1:0] b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/refresh_interval_tracker.sv
module refresh_interval_tracker
  import refresh_sched_pkg::*;
#(
  parameter int OWED_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REFI_W-1:0] cfg_refi,
  input  logic              ref_issued,
  input  logic              sr_enter,
  input  logic              sr_exit,
  output logic [OWED_W-1:0] owed,
  output logic              sr_active,
  output logic              ivl_expire
);
  localparam logic [OWED_W-1:0] OWED_MAX = '1;

  logic [LIM_W-1:0] ivl_cnt;
  logic [LIM_W-1:0] ivl_limit;
  logic             hold;
  logic             owed_inc;
  logic             owed_dec;

  assign ivl_limit  = interval_limit(cfg_refi);
  assign hold       = sr_active | sr_enter;
  assign ivl_expire = !hold && (ivl_cnt >= ivl_limit - 1'b1);
  assign owed_inc   = ivl_expire && (owed != OWED_MAX);
  assign owed_dec   = ref_issued && (owed != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ivl_cnt <= '0;
    end else if (hold || ivl_expire) begin
      ivl_cnt <= '0;
    end else begin
      ivl_cnt <= ivl_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_active <= 1'b0;
    end else if (sr_enter) begin
      sr_active <= 1'b1;
    end else if (sr_exit) begin
      sr_active <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owed <= '0;
    end else begin
      case ({owed_inc, owed_dec})
        2'b10:   owed <= owed + 1'b1;
        2'b01:   owed <= owed - 1'b1;
        default: owed <= owed;
      endcase
    end
  end
endmodule

// File: rtl/refresh_overdue_tracker.sv
module refresh_overdue_tracker
  import refresh_sched_pkg::*;
#(
  parameter int PRESCALE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              owed_nz,
  input  logic [CEIL_W-1:0] cfg_ceiling,
  output logic [CEIL_W-1:0] coarse_units,
  output logic              unit_tick,
  output logic              panic
);
  logic [PRESCALE_W-1:0] fine;

  assign unit_tick = owed_nz && (&fine);
  assign panic     = owed_nz && (coarse_units >= cfg_ceiling);

  always_ff @(posedge clk) begin
    if (!rst_n || !owed_nz) begin
      fine         <= '0;
      coarse_units <= '0;
    end else begin
      fine <= fine + 1'b1;
      if (unit_tick && !(&coarse_units)) begin
        coarse_units <= coarse_units + 1'b1;
      end
    end
  end
endmodule

// File: rtl/refresh_block_timer.sv
module refresh_block_timer
  import refresh_sched_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_issued,
  input  logic              sr_exit,
  input  logic              zq_issued,
  input  logic              mrs_issued,
  input  logic [RFC_W-1:0]  cfg_rfc,
  input  logic [XOFF_W-1:0] cfg_xs_off,
  input  logic [ZQ_W-1:0]   cfg_zq,
  input  logic [MRD_W-1:0]  cfg_mrd,
  output logic              cmd_block
);
  localparam int NSRC = 4;

  logic [BLK_W-1:0] remain;
  logic [BLK_W-1:0] want;
  logic [BLK_W-1:0] src_len [NSRC];
  logic [NSRC-1:0]  src_hit;

  assign src_hit    = {mrs_issued, zq_issued, sr_exit, ref_issued};
  assign src_len[0] = BLK_W'(cfg_rfc);
  assign src_len[1] = exit_delay(cfg_rfc, cfg_xs_off);
  assign src_len[2] = BLK_W'(cfg_zq);
  assign src_len[3] = BLK_W'(cfg_mrd);

  always_comb begin
    want = (remain != '0) ? remain - 1'b1 : '0;
    for (int i = 0; i < NSRC; i++) begin
      if (src_hit[i]) want = longer(want, src_len[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) remain <= '0;
    else        remain <= want;
  end

  assign cmd_block = (remain != '0);
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_sched_pkg::*;
#(
  parameter int OWED_W     = 4,
  parameter int PRESCALE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [14:0]       cfg_refi,
  input  logic [9:0]        cfg_rfc,
  input  logic [6:0]        cfg_ceiling,
  input  logic [3:0]        cfg_xs_off,
  input  logic [9:0]        cfg_zq,
  input  logic [4:0]        cfg_mrd,
  input  logic              ref_issued,
  input  logic              sr_enter,
  input  logic              sr_exit,
  input  logic              zq_issued,
  input  logic              mrs_issued,
  output logic              ref_req,
  output logic              panic_req,
  output logic [OWED_W-1:0] owed,
  output logic              cmd_block
);
  logic              owed_nz;
  logic              sr_active;
  logic              ivl_expire;
  logic              unit_tick;
  logic [CEIL_W-1:0] coarse_units;

  refresh_interval_tracker #(.OWED_W(OWED_W)) u_ivl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_refi  (cfg_refi),
    .ref_issued(ref_issued),
    .sr_enter  (sr_enter),
    .sr_exit   (sr_exit),
    .owed      (owed),
    .sr_active (sr_active),
    .ivl_expire(ivl_expire)
  );

  assign owed_nz = (owed != '0);
  assign ref_req = owed_nz;

  refresh_overdue_tracker #(.PRESCALE_W(PRESCALE_W)) u_ovd (
    .clk         (clk),
    .rst_n       (rst_n),
    .owed_nz     (owed_nz),
    .cfg_ceiling (cfg_ceiling),
    .coarse_units(coarse_units),
    .unit_tick   (unit_tick),
    .panic       (panic_req)
  );

  refresh_block_timer u_blk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_issued(ref_issued),
    .sr_exit   (sr_exit),
    .zq_issued (zq_issued),
    .mrs_issued(mrs_issued),
    .cfg_rfc   (cfg_rfc),
    .cfg_xs_off(cfg_xs_off),
    .cfg_zq    (cfg_zq),
    .cfg_mrd   (cfg_mrd),
    .cmd_block (cmd_block)
  );
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int OWED_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_issued,
  input logic              zq_issued,
  input logic              mrs_issued,
  input logic [9:0]        cfg_rfc,
  input logic [9:0]        cfg_zq,
  input logic [4:0]        cfg_mrd,
  input logic [OWED_W-1:0] owed,
  input logic              ref_req,
  input logic              panic_req,
  input logic              cmd_block,
  input logic              sr_active,
  input logic              ivl_expire,
  input logic              unit_tick,
  input logic [6:0]        coarse_units
);
  AST_OWED_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (owed == $past(owed)) || (owed == $past(owed) + 1'b1) || (owed == $past(owed) - 1'b1)); // R2
  AST_REF_OPENS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_issued && cfg_rfc != '0) |=> cmd_block); // R4
  AST_ZQ_OPENS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (zq_issued && cfg_zq != '0) |=> cmd_block); // R6
  AST_MRS_OPENS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mrs_issued && cfg_mrd != '0) |=> cmd_block); // R7
  AST_PANIC_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    panic_req |-> ref_req); // R9
  AST_TICK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    unit_tick |-> ref_req); // R9
  AST_OVERDUE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_req |=> (coarse_units == '0)); // R10
  AST_SR_NO_ACCRUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_active && !ref_issued) |=> (owed == $past(owed))); // R11
  AST_SR_NO_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    sr_active |-> !ivl_expire); // R11
endmodule

bind refresh_sched refresh_sched_chk #(.OWED_W(OWED_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ref_issued  (ref_issued),
  .zq_issued   (zq_issued),
  .mrs_issued  (mrs_issued),
  .cfg_rfc     (cfg_rfc),
  .cfg_zq      (cfg_zq),
  .cfg_mrd     (cfg_mrd),
  .owed        (owed),
  .ref_req     (ref_req),
  .panic_req   (panic_req),
  .cmd_block   (cmd_block),
  .sr_active   (sr_active),
  .ivl_expire  (ivl_expire),
  .unit_tick   (unit_tick),
  .coarse_units(coarse_units)
);

// File: tb/refresh_sched_test.sv
module refresh_sched_test;
  import refresh_sched_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] cfg_refi = 15'd8;
  logic [9:0]  cfg_rfc = 10'd5;
  logic [6:0]  cfg_ceiling = 7'd2;
  logic [3:0]  cfg_xs_off = 4'd3;
  logic [9:0]  cfg_zq = 10'd40;
  logic [4:0]  cfg_mrd = 5'd12;
  logic        ref_issued = 1'b0, sr_enter = 1'b0, sr_exit = 1'b0;
  logic        zq_issued = 1'b0, mrs_issued = 1'b0;
  logic        ref_req, panic_req, cmd_block;
  logic [3:0]  owed;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  refresh_sched uut (
    .clk(clk), .rst_n(rst_n), .cfg_refi(cfg_refi), .cfg_rfc(cfg_rfc),
    .cfg_ceiling(cfg_ceiling), .cfg_xs_off(cfg_xs_off), .cfg_zq(cfg_zq),
    .cfg_mrd(cfg_mrd), .ref_issued(ref_issued), .sr_enter(sr_enter),
    .sr_exit(sr_exit), .zq_issued(zq_issued), .mrs_issued(mrs_issued),
    .ref_req(ref_req), .panic_req(panic_req), .owed(owed), .cmd_block(cmd_block)
  );

  always #10 clk = ~clk;

  typedef struct packed {
    logic [1:0]  kind;    // 0 refresh, 1 sr exit, 2 zq, 3 mrs
    logic [9:0]  rfc;
    logic [3:0]  xoff;
    logic [9:0]  zq;
    logic [4:0]  mrd;
    logic [11:0] exp_len;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 10'd5,   4'd3,  10'd0,   5'd0,  12'd5},
    '{2'd0, 10'd0,   4'd3,  10'd0,   5'd0,  12'd0},
    '{2'd1, 10'd5,   4'd3,  10'd0,   5'd0,  12'd8},
    '{2'd1, 10'd20,  4'd11, 10'd0,   5'd0,  12'd31},
    '{2'd1, 10'd128, 4'd11, 10'd0,   5'd0,  12'd139},
    '{2'd2, 10'd0,   4'd0,  10'd40,  5'd0,  12'd40},
    '{2'd2, 10'd0,   4'd0,  10'd256, 5'd0,  12'd256},
    '{2'd3, 10'd0,   4'd0,  10'd0,   5'd12, 12'd12}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_block(output int n);
    n = 0;
    while (cmd_block && n < 4000) begin
      n++;
      step();
    end
  endtask

  task automatic drain();
    int guard = 0;
    while (owed != 0 && guard < 200) begin
      ref_issued = 1'b1;
      step();
      ref_issued = 1'b0;
      guard++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R12 watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int o0;
    repeat (3) step();
    // R12: reset state
    chk("R12", int'(owed), 0);
    chk("R12", int'(ref_req), 0);
    chk("R12", int'(panic_req), 0);
    chk("R12", int'(cmd_block), 0);
    rst_n = 1'b1;

    // R1/R3: limit = 16 cycles for field 8
    repeat (15) step();
    chk("R1", int'(owed), 0);
    chk("R3", int'(ref_req), 0);
    step();
    chk("R1", int'(owed), 1);
    chk("R3", int'(ref_req), 1);

    // R2: refresh on the expiry edge (edge 32), then pay back, then ignored at zero
    repeat (15) step();
    ref_issued = 1'b1;
    step();
    chk("R2", int'(owed), 1);
    step();
    ref_issued = 1'b0;
    chk("R2", int'(owed), 0);
    ref_issued = 1'b1;
    step();
    ref_issued = 1'b0;
    chk("R2", int'(owed), 0);
    chk("R3", int'(ref_req), 0);
    while (cmd_block) step();

    // vector table: blocking window lengths (R4 R5 R6 R7)
    for (int i = 0; i < NV; i++) begin
      cfg_rfc = VECS[i].rfc;
      cfg_xs_off = VECS[i].xoff;
      cfg_zq = VECS[i].zq;
      cfg_mrd = VECS[i].mrd;
      if (VECS[i].kind == 2'd1) begin
        sr_enter = 1'b1;
        step();
        sr_enter = 1'b0;
      end
      case (VECS[i].kind)
        2'd0: ref_issued = 1'b1;
        2'd1: sr_exit = 1'b1;
        2'd2: zq_issued = 1'b1;
        default: mrs_issued = 1'b1;
      endcase
      step();
      {ref_issued, sr_exit, zq_issued, mrs_issued} = 4'b0;
      count_block(n);
      case (VECS[i].kind)
        2'd0: chk("R4", n, int'(VECS[i].exp_len));
        2'd1: chk("R5", n, int'(VECS[i].exp_len));
        2'd2: chk("R6", n, int'(VECS[i].exp_len));
        default: chk("R7", n, int'(VECS[i].exp_len));
      endcase
    end

    // R8: overlaps
    cfg_mrd = 5'd30; cfg_rfc = 10'd10;
    mrs_issued = 1'b1; step(); mrs_issued = 1'b0;
    repeat (4) step();
    ref_issued = 1'b1; step(); ref_issued = 1'b0;
    count_block(n);
    chk("R8", n, 25);
    cfg_rfc = 10'd40; cfg_mrd = 5'd12;
    ref_issued = 1'b1; step(); ref_issued = 1'b0;
    repeat (4) step();
    mrs_issued = 1'b1; step(); mrs_issued = 1'b0;
    count_block(n);
    chk("R8", n, 35);
    cfg_zq = 10'd7; cfg_mrd = 5'd20;
    zq_issued = 1'b1; mrs_issued = 1'b1; step();
    zq_issued = 1'b0; mrs_issued = 1'b0;
    count_block(n);
    chk("R8", n, 20);

    // R11: self-refresh pauses accrual, restarts from zero on exit
    cfg_rfc = 10'd5; cfg_xs_off = 4'd3;
    drain();
    sr_enter = 1'b1; step(); sr_enter = 1'b0;
    o0 = int'(owed);
    repeat (100) step();
    chk("R11", int'(owed), o0);
    sr_exit = 1'b1; step(); sr_exit = 1'b0;
    repeat (15) step();
    chk("R11", int'(owed), o0);
    step();
    chk("R11", int'(owed), o0 + 1);

    // R9: panic after ceiling 2 units of 1024 cycles
    cfg_ceiling = 7'd2;
    drain();
    n = 0;
    while (owed == 0 && n < 100) begin n++; step(); end
    repeat (2047) step();
    chk("R9", int'(panic_req), 0);
    step();
    chk("R9", int'(panic_req), 1);
    chk("R2", int'(owed), 15);

    // R10: clear on payback, fresh period afterwards
    drain();
    chk("R10", int'(panic_req), 0);
    n = 0;
    while (owed == 0 && n < 100) begin n++; step(); end
    chk("R10", int'(owed), 1);
    chk("R10", int'(panic_req), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule